// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Page-Table Refill

This block turns a virtual page number into a physical frame number for the process that is currently running. It holds a small number of translations, each tagged with the identifier of the process that owns it. Every stored translation is compared with the incoming request in the same cycle. Because the tags include the process identifier, a context switch does not require clearing the cache. Translations owned by other processes simply fail to match.

When no stored translation matches, the block reads one entry from a single-level page table in memory, through a plain request and response port. The entry's address is a base register plus the page number times the entry size. If the returned entry marks the page as resident, the mapping is installed and the lookup is replayed internally, so the answer comes back as a hit on the freshly written slot. If the page is not resident, the block returns a fault indication and installs nothing. A flush command drops every stored translation at once.

Top module: `pid_tlb`

## Requirements
- R1: Every slot is compared in the same cycle, and at most one slot can match. A request that matches is answered on the cycle right after it is accepted.
- R2: A slot matches only when its page number and its process tag both equal the request. The same page requested by a different process misses, and that leaves the first process's mapping intact.
- R3: On a match, `resp_pfn` is the stored frame, `resp_walked` is 0, and no memory read is issued.
- R4: On a miss, exactly one memory read is issued, at address `pt_base + vpn * PTE_BYTES`. The returned word holds the resident flag at bit `PFN_W` and the frame number in bits `PFN_W-1:0`.
- R5: If the returned entry is resident, the mapping is installed and the replayed lookup hits. The response then carries that frame with `resp_walked` = 1. A later identical request hits with `resp_walked` = 0.
- R6: While the block is idle, a flush invalidates every slot, so all following requests miss. `req_ready` is low during the flush cycle.
- R7: If the returned entry is not resident, the response has `resp_fault` = 1, `resp_walked` = 1 and `resp_pfn` = 0. Nothing is installed, so repeating the request walks the page table again.
- R8: A refill uses the lowest-numbered empty slot. When all slots are full, it uses a round-robin pointer instead. The pointer starts at slot 0 after reset and moves forward by one on each such replacement.
- R9: From the moment a miss is accepted until its response appears, `req_ready` stays low and only one memory read is outstanding.
- R10: After reset, every slot is empty, `req_ready` is 1, and neither `resp_valid` nor `mem_req_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | VPN_W | Requested virtual page number |
| req_pid | input | PID_W | Identifier of the current process |
| flush | input | 1 | Invalidate all slots |
| pt_base | input | ADDR_W | Page table base address |
| resp_valid | output | 1 | Response pulse |
| resp_pfn | output | PFN_W | Translated frame number |
| resp_walked | output | 1 | Response required a page-table read |
| resp_fault | output | 1 | Page not resident |
| mem_req_valid | output | 1 | Page-table read request, one cycle |
| mem_req_addr | output | ADDR_W | Page-table entry address |
| mem_resp_valid | input | 1 | Page-table read data valid |
| mem_resp_data | input | PFN_W+1 | Resident flag and frame number |

## Verification
The assertions assume that memory returns exactly one response for each read, and only while the block is waiting for it. They also assume that `pt_base` does not change during a walk. The bench's memory model answers each read once, a fixed three cycles later, and never answers on its own. The bench changes page-table contents and the base only while the block is idle. It raises flush only between translations, so a flush never lands on a refill in progress.

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int VPN_W     = 8,
  parameter int PFN_W     = 8,
  parameter int PID_W     = 4,
  parameter int ENTRIES   = 4,
  parameter int ADDR_W    = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [PID_W-1:0]  req_pid,
  input  logic              flush,
  input  logic [ADDR_W-1:0] pt_base,
  output logic              resp_valid,
  output logic [PFN_W-1:0]  resp_pfn,
  output logic              resp_walked,
  output logic              resp_fault,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [PFN_W:0]    mem_resp_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RETRY} state_t;
  state_t state;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_vpn [ENTRIES];
  logic [PID_W-1:0]   tag_pid [ENTRIES];
  logic [PFN_W-1:0]   frame   [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic [VPN_W-1:0]   pend_vpn;
  logic [PID_W-1:0]   pend_pid;

  logic [VPN_W-1:0]   key_vpn;
  logic [PID_W-1:0]   key_pid;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim;
  logic               any_hit, any_free, accept, flush_go, install;

  assign key_vpn  = (state == S_RETRY) ? pend_vpn : req_vpn;
  assign key_pid  = (state == S_RETRY) ? pend_pid : req_pid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && tag_vpn[g] == key_vpn && tag_pid[g] == key_pid;
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!vld[i])    free_idx = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign any_free  = ~&vld;
  assign victim    = any_free ? free_idx : rr;
  assign req_ready = (state == S_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign flush_go  = flush && (state == S_IDLE);
  assign install   = (state == S_WAIT) && mem_resp_valid && mem_resp_data[PFN_W];

  assign mem_req_valid = (state == S_ISSUE);
  assign mem_req_addr  = pt_base + ADDR_W'(pend_vpn) * ADDR_W'(PTE_BYTES);

  always_ff @(posedge clk) begin
    if (install) begin
      tag_vpn[victim] <= pend_vpn;
      tag_pid[victim] <= pend_pid;
      frame[victim]   <= mem_resp_data[PFN_W-1:0];
    end
    if (accept) begin
      pend_vpn <= req_vpn;
      pend_pid <= req_pid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      vld         <= '0;
      rr          <= '0;
      resp_valid  <= 1'b0;
      resp_pfn    <= '0;
      resp_walked <= 1'b0;
      resp_fault  <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      if (flush_go) vld <= '0;
      if (install) begin
        vld[victim] <= 1'b1;
        if (!any_free) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      case (state)
        S_IDLE: if (accept) begin
          if (any_hit) begin
            resp_valid  <= 1'b1;
            resp_pfn    <= frame[hit_idx];
            resp_walked <= 1'b0;
            resp_fault  <= 1'b0;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (mem_resp_valid) begin
          if (mem_resp_data[PFN_W]) begin
            state <= S_RETRY;
          end else begin
            state       <= S_IDLE;
            resp_valid  <= 1'b1;
            resp_pfn    <= '0;
            resp_walked <= 1'b1;
            resp_fault  <= 1'b1;
          end
        end
        S_RETRY: begin
          state       <= S_IDLE;
          resp_valid  <= 1'b1;
          resp_pfn    <= frame[hit_idx];
          resp_walked <= 1'b1;
          resp_fault  <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R1
  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> (resp_valid && !resp_walked && !mem_req_valid)); // R3
  AST_RETRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RETRY) |-> any_hit); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_go |=> (vld == '0)); // R6
  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && mem_resp_valid && !mem_resp_data[PFN_W]) |=> ($stable(vld) && resp_fault)); // R7
  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> (!mem_req_valid && !req_ready)); // R9
endmodule

// File: tb/pid_tlb_tb_top.sv
module pid_tlb_tb_top;
  localparam logic [15:0] PT_BASE = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vpn = '0;
  logic [3:0]  req_pid = '0;
  logic        flush = 1'b0;
  logic        resp_valid, resp_walked, resp_fault, mem_req_valid;
  logic [7:0]  resp_pfn;
  logic [15:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [8:0]  mem_resp_data = '0;

  int checks = 0;
  int fails = 0;
  int mreq_cnt = 0;
  int dly = 0;
  logic [15:0] last_addr = '0;
  logic [8:0]  pt [256];
  bit done = 0;

  always #5 clk = ~clk;

  pid_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid), .flush(flush), .pt_base(PT_BASE),
    .resp_valid(resp_valid), .resp_pfn(resp_pfn), .resp_walked(resp_walked),
    .resp_fault(resp_fault), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid) begin
      mreq_cnt  <= mreq_cnt + 1;
      last_addr <= mem_req_addr;
      dly       <= 3;
    end else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        mem_resp_valid <= 1'b1;
        mem_resp_data  <= pt[8'((last_addr - PT_BASE) >> 1)];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] ref_pfn(input logic [7:0] vpn);
    return pt[vpn][8] ? pt[vpn][7:0] : 8'h00;
  endfunction

  task automatic run(input logic [3:0] pid, input logic [7:0] vpn, input bit ew, input bit ef, input logic [7:0] ep);
    int m0, lat;
    bit leak;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    m0 = mreq_cnt;
    req_pid = pid; req_vpn = vpn; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; leak = 0;
    while (!resp_valid) begin
      if (req_ready) leak = 1;
      @(negedge clk);
      lat++;
    end
    chk(resp_walked == ew, ew ? "R5" : "R3", "walked flag", resp_walked, ew);
    chk(resp_fault == ef, "R7", "fault flag", resp_fault, ef);
    chk(resp_pfn == ep, ew ? "R5" : "R3", "frame", resp_pfn, ep);
    chk((mreq_cnt - m0) == int'(ew), "R4", "memory reads", mreq_cnt - m0, ew);
    if (ew) begin
      chk(last_addr == PT_BASE + 16'(vpn) * 16'd2, "R4", "entry address", last_addr, PT_BASE + 16'(vpn) * 16'd2);
      chk(!leak, "R9", "ready during walk", leak, 0);
    end else begin
      chk(lat == 0, "R1", "hit latency", lat, 0);
    end
  endtask

  localparam logic [13:0] VEC [9] = '{
    {4'd1, 8'h10, 1'b1, 1'b0},
    {4'd1, 8'h10, 1'b0, 1'b0},
    {4'd1, 8'h11, 1'b1, 1'b0},
    {4'd2, 8'h10, 1'b1, 1'b0},
    {4'd1, 8'h10, 1'b0, 1'b0},
    {4'd1, 8'h33, 1'b1, 1'b1},
    {4'd1, 8'h33, 1'b1, 1'b1},
    {4'd2, 8'h10, 1'b0, 1'b0},
    {4'd1, 8'h11, 1'b0, 1'b0}
  };

  initial begin
    for (int v = 0; v < 256; v++) pt[v] = {1'b1, 8'(v) ^ 8'h5A};
    pt[8'h33] = 9'h000;
    do_reset();
    // R10 reset state
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(resp_valid == 1'b0, "R10", "resp after reset", resp_valid, 0);
    chk(mem_req_valid == 1'b0, "R10", "mem req after reset", mem_req_valid, 0);

    foreach (VEC[i]) run(VEC[i][13:10], VEC[i][9:2], VEC[i][1], VEC[i][0], ref_pfn(VEC[i][9:2]));

    // R8 replacement order
    do_reset();
    for (int v = 8'h20; v <= 8'h23; v++) run(4'd1, 8'(v), 1'b1, 1'b0, ref_pfn(8'(v)));
    run(4'd1, 8'h24, 1'b1, 1'b0, ref_pfn(8'h24));
    run(4'd1, 8'h21, 1'b0, 1'b0, ref_pfn(8'h21)); // R8 slot 1 kept
    run(4'd1, 8'h20, 1'b1, 1'b0, ref_pfn(8'h20)); // R8 slot 0 evicted first
    run(4'd1, 8'h22, 1'b0, 1'b0, ref_pfn(8'h22)); // R8 slot 2 kept
    run(4'd1, 8'h23, 1'b0, 1'b0, ref_pfn(8'h23));
    run(4'd1, 8'h21, 1'b1, 1'b0, ref_pfn(8'h21)); // R8 slot 1 evicted second

    // R2 process tag separation
    do_reset();
    run(4'd3, 8'h40, 1'b1, 1'b0, 8'h40 ^ 8'h5A);
    pt[8'h40] = {1'b1, 8'hC3};
    run(4'd4, 8'h40, 1'b1, 1'b0, 8'hC3); // R2 other process misses
    run(4'd3, 8'h40, 1'b0, 1'b0, 8'h40 ^ 8'h5A); // R2 first mapping intact
    run(4'd4, 8'h40, 1'b0, 1'b0, 8'hC3);

    // R6 flush
    @(negedge clk);
    flush = 1'b1;
    #1 chk(req_ready == 1'b0, "R6", "ready during flush", req_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    run(4'd3, 8'h40, 1'b1, 1'b0, 8'hC3); // R6 flushed entry walks
    run(4'd4, 8'h40, 1'b1, 1'b0, 8'hC3); // R6 flushed entry walks

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule